// File: doc/BRIEF.md
# Open-Drain Reset Pin Controller

This block sequences the internal reset of a chip around a single active-low, open-drain reset pin that serves as both input and output. The controller never drives the pin high. It either pulls the pin low or lets it float. The sampled pin level enters through a synchronizer. A low level is taken as an external hardware reset only once it has been seen for two consecutive cycles. While the pin stays low the internal reset is held, and it is released a fixed number of cycles after the pin goes high again.

A software reset request always resets the chip. When its pin-drive option is set, the controller also pulls the pin low for a fixed number of cycles, so that other devices on the same line are reset too. A watchdog error always uses the pin-driving form. After the controller lets go of the pin it checks the line again. If some other device is still holding the pin low, the event becomes a full hardware reset. A second watchdog error, with no hardware or power-on reset in between, locks the chip in reset. Only a power-on reset or a qualified external low ends that lock.

The synchronous power-on reset input also acts as the block's own reset. After power-on, the internal reset stays asserted until the pin is seen high.

Top module: `rstpin_ctrl`

## Requirements
- R1: During power-on reset and after it, `chip_rst`=1, `pin_pull_low`=0, `hw_flag`=0 and `wdt_locked`=0. If the pin is high when power-on reset ends, `chip_rst` falls on the 3rd rising edge after that. If the pin is low, `chip_rst` stays 1 until the 3rd edge after the pin goes high.
- R2: In normal operation, a pin low for a single cycle has no effect. A pin low for 2 or more cycles raises `chip_rst` at the 4th edge after the pin fell.
- R3: During a hardware reset, `chip_rst` stays 1 while the pin is low. It falls HW_LEN cycles after the synchronized pin is high again, at edge max(L+3,5)+HW_LEN-1 counted from the falling edge of a low pulse of L cycles.
- R4: A software request with the drive option set (`sw_drive`=1) asserts `pin_pull_low` at the next edge for exactly DRV_LEN cycles, with `chip_rst` asserted.
- R5: A software request with `sw_drive`=0 never asserts `pin_pull_low`, and holds `chip_rst` for exactly SW_LEN cycles.
- R6: A first watchdog error drives the pin exactly like R4, and `wdt_locked` stays 0.
- R7: If the pin is still low when the line is checked 3 cycles after the controller releases it, the controller runs the hardware reset of R3.
- R8: `hw_flag` rises on the edge where a hardware reset ends, together with the fall of `chip_rst`. It is cleared when a software or watchdog reset starts.
- R9: A second watchdog error, with no hardware or power-on reset since the first, sets `wdt_locked` and holds `chip_rst`=1 with the pin released. While locked, software requests and further watchdog errors have no effect.
- R10: The lock ends only through a qualified pin low, which starts a hardware reset, or through power-on reset. Either one also forgets the earlier watchdog error.
- R11: After a pin-driving reset whose line comes back high, `chip_rst` falls DRV_LEN+3 cycles after the request edge, and `hw_flag` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| pin_in | input | 1 | Level read back from the reset pin (0 = low) |
| sw_req | input | 1 | One-cycle software reset request |
| sw_drive | input | 1 | Request option: also pull the pin low |
| wdt_err | input | 1 | One-cycle watchdog error indication |
| pin_pull_low | output | 1 | Enable for the pin pull-down (0 = tri-state) |
| chip_rst | output | 1 | Internal reset, active high |
| hw_flag | output | 1 | Last completed reset was a hardware reset |
| wdt_locked | output | 1 | Held in reset after a repeated watchdog error |

## Verification
The bench builds the controller with DRV_LEN=16, HW_LEN=8, SW_LEN=6 and two synchronizer stages. These values are short enough that every sequence can be walked edge by edge against closed-form arrival times. The external low pulse length is swept from 1 to 5 cycles, which covers the rejected pulse, the shortest accepted pulse, and pulses that end both before and after the hardware reset begins. With the bench modelling the wired line, the same settings also reach an external hold that outlasts the controller's own drive, both watchdog lock exits, and the clean release path.

// File: rtl/rstpin_pkg.sv
package rstpin_pkg;

    typedef enum logic [2:0] {
        ST_POR   = 3'd0,
        ST_RUN   = 3'd1,
        ST_DRIVE = 3'd2,
        ST_CHECK = 3'd3,
        ST_HWSEQ = 3'd4,
        ST_SWSEQ = 3'd5,
        ST_LOCK  = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic pull_low;
        logic chip_rst;
        logic locked;
    } pin_ctl_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic pin_ctl_t decode_state(input seq_state_e s);
        pin_ctl_t c;
        c.pull_low = (s == ST_DRIVE);
        c.chip_rst = (s != ST_RUN);
        c.locked   = (s == ST_LOCK);
        return c;
    endfunction

endpackage

// File: rtl/rstpin_sync.sv
module rstpin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rstpin_qual.sv
module rstpin_qual #(
    parameter int QUAL_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_hi,
    output logic qualified
);
    localparam int RW = $clog2(QUAL_LEN) + 1;
    localparam logic [RW-1:0] RUN_SAT = RW'(QUAL_LEN - 1);

    logic [RW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)                  low_run <= '0;
        else if (pin_hi)          low_run <= '0;
        else if (low_run != RUN_SAT) low_run <= low_run + 1'b1;
    end

    assign qualified = !pin_hi && (low_run == RUN_SAT);
endmodule

// File: rtl/rstpin_seq.sv
module rstpin_seq
    import rstpin_pkg::*;
#(
    parameter int DRV_LEN = 16,
    parameter int HW_LEN  = 8,
    parameter int SW_LEN  = 6,
    parameter int CHK_LEN = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_hi,
    input  logic       qualified,
    input  logic       sw_req,
    input  logic       sw_drive,
    input  logic       wdt_err,
    output seq_state_e state,
    output logic       hw_flag
);
    localparam int CNT_MAX = max2(max2(DRV_LEN, HW_LEN), max2(SW_LEN, CHK_LEN));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] DRV_LAST = CNT_W'(DRV_LEN - 1);
    localparam logic [CNT_W-1:0] HW_LAST  = CNT_W'(HW_LEN - 1);
    localparam logic [CNT_W-1:0] SW_LAST  = CNT_W'(SW_LEN - 1);
    localparam logic [CNT_W-1:0] CHK_LAST = CNT_W'(CHK_LEN - 1);

    seq_state_e       st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             flag_q, flag_n;
    logic             seen_q, seen_n;

    always_comb begin
        st_n   = st_q;
        cnt_n  = cnt_q;
        flag_n = flag_q;
        seen_n = seen_q;
        case (st_q)
            ST_POR: begin
                if (pin_hi) st_n = ST_RUN;
            end
            ST_RUN: begin
                cnt_n = '0;
                if (qualified) begin
                    st_n = ST_HWSEQ;
                end else if (wdt_err) begin
                    flag_n = 1'b0;
                    if (seen_q) begin
                        st_n = ST_LOCK;
                    end else begin
                        seen_n = 1'b1;
                        st_n   = ST_DRIVE;
                    end
                end else if (sw_req) begin
                    flag_n = 1'b0;
                    st_n   = sw_drive ? ST_DRIVE : ST_SWSEQ;
                end
            end
            ST_DRIVE: begin
                if (cnt_q == DRV_LAST) begin
                    st_n  = ST_CHECK;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_CHECK: begin
                if (cnt_q == CHK_LAST) begin
                    st_n  = qualified ? ST_HWSEQ : ST_RUN;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_HWSEQ: begin
                seen_n = 1'b0;
                if (!pin_hi) begin
                    cnt_n = '0;
                end else if (cnt_q == HW_LAST) begin
                    st_n   = ST_RUN;
                    cnt_n  = '0;
                    flag_n = 1'b1;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_SWSEQ: begin
                if (qualified) begin
                    st_n  = ST_HWSEQ;
                    cnt_n = '0;
                end else if (cnt_q == SW_LAST) begin
                    st_n  = ST_RUN;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_LOCK: begin
                if (qualified) begin
                    st_n  = ST_HWSEQ;
                    cnt_n = '0;
                end
            end
            default: begin
                st_n  = ST_POR;
                cnt_n = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_POR;
            cnt_q  <= '0;
            flag_q <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            cnt_q  <= cnt_n;
            flag_q <= flag_n;
            seen_q <= seen_n;
        end
    end

    assign state   = st_q;
    assign hw_flag = flag_q;
endmodule

// File: rtl/rstpin_ctrl.sv
module rstpin_ctrl
    import rstpin_pkg::*;
#(
    parameter int DRV_LEN     = 16,
    parameter int HW_LEN      = 8,
    parameter int SW_LEN      = 6,
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_LEN    = 2
) (
    input  logic clk,
    input  logic por,
    input  logic pin_in,
    input  logic sw_req,
    input  logic sw_drive,
    input  logic wdt_err,
    output logic pin_pull_low,
    output logic chip_rst,
    output logic hw_flag,
    output logic wdt_locked
);
    localparam int CHK_LEN = SYNC_STAGES + 1;

    logic       pin_hi;
    logic       qualified;
    seq_state_e state;
    pin_ctl_t   ctl;

    rstpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (por),
        .d   (pin_in),
        .q   (pin_hi)
    );

    rstpin_qual #(.QUAL_LEN(QUAL_LEN)) u_qual (
        .clk       (clk),
        .rst       (por),
        .pin_hi    (pin_hi),
        .qualified (qualified)
    );

    rstpin_seq #(
        .DRV_LEN (DRV_LEN),
        .HW_LEN  (HW_LEN),
        .SW_LEN  (SW_LEN),
        .CHK_LEN (CHK_LEN)
    ) u_seq (
        .clk       (clk),
        .rst       (por),
        .pin_hi    (pin_hi),
        .qualified (qualified),
        .sw_req    (sw_req),
        .sw_drive  (sw_drive),
        .wdt_err   (wdt_err),
        .state     (state),
        .hw_flag   (hw_flag)
    );

    assign ctl          = decode_state(state);
    assign pin_pull_low = ctl.pull_low;
    assign chip_rst     = ctl.chip_rst;
    assign wdt_locked   = ctl.locked;
endmodule

// File: rtl/rstpin_chk.sv
module rstpin_chk #(
    parameter int DRV_LEN = 16
) (
    input logic clk,
    input logic por,
    input logic pin_pull_low,
    input logic chip_rst,
    input logic hw_flag,
    input logic wdt_locked
);
    logic [15:0] drive_run;

    always_ff @(posedge clk) begin
        if (por)               drive_run <= '0;
        else if (pin_pull_low) drive_run <= drive_run + 1'b1;
        else                   drive_run <= '0;
    end

    // R1: first cycle after power-on reset is still in reset
    a_r1_reset_after_por: assert property (@(posedge clk) disable iff (por)
        $past(por) |-> chip_rst);

    // R4: pin is only driven while the chip is held in reset
    a_r4_drive_in_reset: assert property (@(posedge clk) disable iff (por)
        pin_pull_low |-> chip_rst);

    // R4: a drive pulse lasts exactly DRV_LEN cycles
    a_r4_drive_length: assert property (@(posedge clk) disable iff (por)
        (!pin_pull_low && $past(pin_pull_low)) |-> (drive_run == 16'(DRV_LEN)));

    // R8: flag rises only together with the end of a reset
    a_r8_flag_at_release: assert property (@(posedge clk) disable iff (por)
        $rose(hw_flag) |-> $fell(chip_rst));

    // R9: locked means held in reset with the pin released
    a_r9_lock_holds: assert property (@(posedge clk) disable iff (por)
        wdt_locked |-> (chip_rst && !pin_pull_low));

    // R10: leaving the lock goes into another reset sequence
    a_r10_lock_exit: assert property (@(posedge clk) disable iff (por)
        $fell(wdt_locked) |-> chip_rst);
endmodule

bind rstpin_ctrl rstpin_chk #(.DRV_LEN(DRV_LEN)) u_chk (
    .clk          (clk),
    .por          (por),
    .pin_pull_low (pin_pull_low),
    .chip_rst     (chip_rst),
    .hw_flag      (hw_flag),
    .wdt_locked   (wdt_locked)
);

// File: tb/tb_rstpin_ctrl.sv
module tb_rstpin_ctrl;
    localparam int DRV_LEN = 16;
    localparam int HW_LEN  = 8;
    localparam int SW_LEN  = 6;
    localparam int CHK     = 3;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic ext_low = 1'b0;
    logic sw_req = 1'b0;
    logic sw_drive = 1'b0;
    logic wdt_err = 1'b0;
    logic pin_in;
    logic pin_pull_low, chip_rst, hw_flag, wdt_locked;

    int n_cmp = 0;
    int n_bad = 0;

    assign pin_in = !(pin_pull_low || ext_low);

    always #5 clk = ~clk;

    rstpin_ctrl #(
        .DRV_LEN (DRV_LEN),
        .HW_LEN  (HW_LEN),
        .SW_LEN  (SW_LEN),
        .SYNC_STAGES (2),
        .QUAL_LEN (2)
    ) dut (
        .clk (clk), .por (por), .pin_in (pin_in),
        .sw_req (sw_req), .sw_drive (sw_drive), .wdt_err (wdt_err),
        .pin_pull_low (pin_pull_low), .chip_rst (chip_rst),
        .hw_flag (hw_flag), .wdt_locked (wdt_locked)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        sw_req  = 1'b0;
        wdt_err = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // External low pulse of L cycles starting from normal operation
    task automatic qual_case(input int L);
        int ex;
        int last;
        ex = (L + 3 > 5 ? L + 3 : 5) + HW_LEN - 1;
        last = (L >= 2) ? ex + 1 : L + 6;
        ext_low = 1'b1;
        for (int k = 1; k <= last; k++) begin
            step();
            if (k == L) ext_low = 1'b0;
            if (k <= 4)
                chk("R2", $sformatf("chip_rst L=%0d k=%0d", L, k), chip_rst,
                    (L >= 2 && k >= 4) ? 1 : 0);
            else
                chk("R3", $sformatf("chip_rst L=%0d k=%0d", L, k), chip_rst,
                    (L >= 2 && k < ex) ? 1 : 0);
            if (L >= 2 && k == ex)
                chk("R8", $sformatf("hw_flag at release L=%0d", L), hw_flag, 1);
        end
    endtask

    // Pin-driving reset with the line coming back high
    task automatic drive_case(input bit use_wdt, input string req);
        if (use_wdt) wdt_err = 1'b1;
        else begin sw_req = 1'b1; sw_drive = 1'b1; end
        for (int k = 1; k <= DRV_LEN + CHK + 3; k++) begin
            step();
            chk(req, $sformatf("pin_pull_low k=%0d", k), pin_pull_low, (k <= DRV_LEN) ? 1 : 0);
            chk("R11", $sformatf("chip_rst k=%0d", k), chip_rst, (k <= DRV_LEN + CHK) ? 1 : 0);
            chk("R8", $sformatf("hw_flag k=%0d", k), hw_flag, 0);
            chk(req, $sformatf("wdt_locked k=%0d", k), wdt_locked, 0);
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        int ex;
        // R1: power-on with the pin held low from outside
        ext_low = 1'b1;
        idle(4);
        chk("R1", "chip_rst in por", chip_rst, 1);
        chk("R1", "pin_pull_low in por", pin_pull_low, 0);
        chk("R1", "hw_flag in por", hw_flag, 0);
        chk("R1", "wdt_locked in por", wdt_locked, 0);
        por = 1'b0;
        for (int k = 1; k <= 10; k++) begin
            step();
            chk("R1", $sformatf("held while pin low k=%0d", k), chip_rst, 1);
        end
        ext_low = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            step();
            chk("R1", $sformatf("release after por k=%0d", k), chip_rst, (k < 3) ? 1 : 0);
        end
        idle(3);

        // R2 R3 R8: sweep of external pulse lengths
        for (int L = 1; L <= 5; L++) begin
            qual_case(L);
            idle(3);
        end

        // R4 R11 R8: software reset with pin drive, clears flag
        drive_case(1'b0, "R4");
        idle(3);

        // R5: software reset without pin drive
        sw_req = 1'b1; sw_drive = 1'b0;
        for (int k = 1; k <= SW_LEN + 3; k++) begin
            step();
            chk("R5", $sformatf("pin_pull_low k=%0d", k), pin_pull_low, 0);
            chk("R5", $sformatf("chip_rst k=%0d", k), chip_rst, (k <= SW_LEN) ? 1 : 0);
        end
        idle(3);

        // R6: first watchdog error
        drive_case(1'b1, "R6");
        idle(3);

        // R9: second watchdog error locks; requests ignored
        wdt_err = 1'b1;
        for (int k = 1; k <= 30; k++) begin
            step();
            chk("R9", $sformatf("wdt_locked k=%0d", k), wdt_locked, 1);
            chk("R9", $sformatf("chip_rst k=%0d", k), chip_rst, 1);
            chk("R9", $sformatf("pin_pull_low k=%0d", k), pin_pull_low, 0);
            if (k == 10) begin sw_req = 1'b1; sw_drive = 1'b1; end
            if (k == 20) wdt_err = 1'b1;
        end

        // R10: qualified pin low ends the lock into a hardware reset
        ex = 6 + HW_LEN - 1;
        ext_low = 1'b1;
        for (int k = 1; k <= ex + 1; k++) begin
            step();
            if (k == 3) ext_low = 1'b0;
            chk("R10", $sformatf("wdt_locked k=%0d", k), wdt_locked, (k < 4) ? 1 : 0);
            chk("R10", $sformatf("chip_rst k=%0d", k), chip_rst, (k < ex) ? 1 : 0);
        end
        chk("R10", "hw_flag after lock exit", hw_flag, 1);
        idle(3);
        // R10: watchdog history forgotten, next error only drives
        drive_case(1'b1, "R10");
        idle(3);
        wdt_err = 1'b1;
        step();
        chk("R10", "locked again", wdt_locked, 1);
        // R10: power-on reset clears the lock
        por = 1'b1;
        idle(2);
        chk("R10", "lock cleared by por", wdt_locked, 0);
        por = 1'b0;
        idle(5);
        chk("R1", "running after por", chip_rst, 0);

        // R7: external device keeps the line low after release
        wdt_err = 1'b1;
        ex = 23 + 3 + HW_LEN - 1;
        for (int k = 1; k <= ex + 2; k++) begin
            step();
            if (k == 5)  ext_low = 1'b1;
            if (k == 23) ext_low = 1'b0;
            chk("R7", $sformatf("pin_pull_low k=%0d", k), pin_pull_low, (k <= DRV_LEN) ? 1 : 0);
            chk("R7", $sformatf("chip_rst k=%0d", k), chip_rst, (k < ex) ? 1 : 0);
            if (k == ex) chk("R8", "hw_flag after held line", hw_flag, 1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule